// File: doc/BRIEF.md
# Reverse-Subtract-Immediate Execute Unit

This block is the execute stage for a group of four 32-bit instructions that subtract a source register from an immediate, computing immediate minus register rather than the usual order. It takes the instruction word, the value already read for the source register, and a valid strobe. In the same cycle it returns the destination index, the 32-bit result and a write enable. It also holds the processor's carry flag, which is updated at the clock edge that ends the instruction. A carry of 1 means the subtraction needed no borrow, and a carry of 0 means it did.

Two opcode bits choose the variant. The use-carry bit replaces the constant +1 of a plain subtraction with the current carry flag, so a multi-word subtraction can be chained. The keep-carry bit freezes the flag. The immediate is normally the 16-bit field, sign-extended. A dedicated prefix instruction can load the upper 16 bits ahead of time. A small two-state machine tracks this: PFX_IDLE moves to PFX_ARMED when a valid prefix arrives. It moves from PFX_ARMED back to PFX_IDLE after the next valid non-prefix word, and stays in PFX_ARMED with a new value if another prefix arrives. A cycle with the strobe low leaves the state as it is.

Top module: `rsub_imm_exec`

## Requirements
- R1: Word bit 31 is the first opcode bit. A word is one of the four instructions when bits [31:29] equal 001 and bit 26 is 1. Bit 28 is the keep-carry bit and bit 27 is the use-carry bit. Any other word gives no write enable and leaves the carry flag unchanged.
- R2: With use-carry 0, the result is the immediate minus the source value, computed as ~src + imm + 1.
- R3: With use-carry 1, the result is ~src + imm + carry flag.
- R4: With keep-carry 0, the carry flag takes the carry-out of the 33-bit sum at the clock edge. It is 1 when no borrow occurred.
- R5: With keep-carry 1, the carry flag keeps its value.
- R6: The immediate is bits [15:0], sign-extended to 32 bits, unless a prefix is armed.
- R7: The prefix word has bits [31:26] = 101100 and bits [25:16] = 0. It arms the unit with bits [15:0] as the upper half. The next valid instruction then uses the immediate {upper half, its own bits [15:0]}. The prefix itself writes nothing and leaves the carry flag unchanged.
- R8: An armed prefix is dropped by the next valid non-prefix word, whether or not that word uses it. Cycles with the strobe low do not drop it.
- R9: The destination index is bits [25:21] and the source index is bits [20:16]. The write enable stays low when the destination index is 0, but the carry flag is still updated.
- R10: Reset clears the carry flag and disarms any pending prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_word | input | 32 | Instruction word |
| src_val | input | 32 | Value read for the source register |
| src_idx | output | 5 | Source register index |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Result |
| carry_next | output | 1 | Carry flag value after this cycle's edge |
| carry_flag | output | 1 | Current carry flag |

## Verification
Two functions can fall on the same instruction. An armed prefix can widen the immediate of an instruction whose use-carry bit pulls in a carry flag set by the instruction just before it. The bench sets this up by placing a carry-producing subtraction immediately before the prefix and then issuing a use-carry instruction. Its reference model, which keeps its own carry and prefix state, must agree with the 32-bit result and the carry-out. The bench also lets an idle cycle, a non-matching word and a reset fall between a prefix and its consumer, and judges from the result whether the immediate was widened or sign-extended.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
    localparam int XLEN  = 32;
    localparam int RIDX  = 5;
    localparam int HALF  = XLEN / 2;
    localparam int OPW   = 6;
    localparam logic [OPW-1:0] PFX_OP = 6'b101100;

    typedef enum logic {
        PFX_IDLE,
        PFX_ARMED
    } pfx_state_e;

    typedef struct packed {
        logic            is_rsub;
        logic            is_pfx;
        logic            keep;
        logic            use_c;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs;
        logic [HALF-1:0] field;
    } dec_t;
endpackage

// File: rtl/rsub_decode.sv
module rsub_decode
    import rsub_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output dec_t            dec
);
    localparam int OP_LO = XLEN - OPW;
    localparam int RD_LO = OP_LO - RIDX;
    localparam int RS_LO = RD_LO - RIDX;

    logic [OPW-1:0] op;

    always_comb begin
        op          = word[XLEN-1:OP_LO];
        dec.is_rsub = (op[5:3] == 3'b001) && op[0];
        dec.keep    = op[2];
        dec.use_c   = op[1];
        dec.is_pfx  = (op == PFX_OP) && (word[OP_LO-1:HALF] == '0);
        dec.rd      = word[OP_LO-1:RD_LO];
        dec.rs      = word[RD_LO-1:RS_LO];
        dec.field   = word[HALF-1:0];
    end
endmodule

// File: rtl/rsub_imm_gen.sv
module rsub_imm_gen
    import rsub_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            is_pfx,
    input  logic [HALF-1:0] field,
    output logic [XLEN-1:0] imm
);
    pfx_state_e      state, state_nx;
    logic [HALF-1:0] hi_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            PFX_IDLE:  if (in_valid && is_pfx) state_nx = PFX_ARMED;
            PFX_ARMED: if (in_valid && !is_pfx) state_nx = PFX_IDLE;
            default:   state_nx = PFX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PFX_IDLE;
            hi_q  <= '0;
        end else begin
            state <= state_nx;
            if (in_valid && is_pfx) hi_q <= field;
        end
    end

    always_comb begin
        unique case (state)
            PFX_ARMED: imm = {hi_q, field};
            default:   imm = {{HALF{field[HALF-1]}}, field};
        endcase
    end

    // R8
    pfx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_pfx) |=> (state == PFX_IDLE));
    // R7
    pfx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_pfx) |=> (state == PFX_ARMED && hi_q == $past(field)));
    // R8
    pfx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state));
endmodule

// File: rtl/rsub_alu.sv
module rsub_alu
    import rsub_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] imm,
    input  logic            use_c,
    input  logic            cflag,
    output logic [XLEN-1:0] res,
    output logic            cout
);
    logic [XLEN:0] sum;
    logic          cin;

    always_comb begin
        cin  = use_c ? cflag : 1'b1;
        sum  = {1'b0, ~src} + {1'b0, imm} + {{XLEN{1'b0}}, cin};
        res  = sum[XLEN-1:0];
        cout = sum[XLEN];
    end
endmodule

// File: rtl/rsub_imm_exec.sv
module rsub_imm_exec
    import rsub_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_word,
    input  logic [XLEN-1:0] src_val,
    output logic [RIDX-1:0] src_idx,
    output logic            wr_en,
    output logic [RIDX-1:0] wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic            carry_next,
    output logic            carry_flag
);
    dec_t            dec;
    logic [XLEN-1:0] imm;
    logic            cout;
    logic            fire;

    rsub_decode u_dec (.word(in_word), .dec(dec));

    rsub_imm_gen u_imm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .is_pfx(dec.is_pfx), .field(dec.field), .imm(imm)
    );

    rsub_alu u_alu (
        .src(src_val), .imm(imm), .use_c(dec.use_c),
        .cflag(carry_flag), .res(wr_data), .cout(cout)
    );

    always_comb begin
        fire       = in_valid && dec.is_rsub;
        src_idx    = dec.rs;
        wr_idx     = dec.rd;
        wr_en      = fire && (dec.rd != '0);
        carry_next = (fire && !dec.keep) ? cout : carry_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_flag <= 1'b0;
        else        carry_flag <= carry_next;
    end

    // R1
    no_match_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && dec.is_rsub) |-> !wr_en);
    // R1
    no_match_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && dec.is_rsub) |=> $stable(carry_flag));
    // R5
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.is_rsub && dec.keep) |=> $stable(carry_flag));
    // R4
    carry_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.is_rsub && !dec.keep) |=> (carry_flag == $past(cout)));
    // R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == '0) |-> !wr_en);
endmodule

// File: tb/rsub_imm_exec_tb.sv
`timescale 1ns/1ps
module rsub_imm_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [31:0] src_val = '0;
    logic [4:0]  src_idx;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        carry_next;
    logic        carry_flag;

    always #2.5 clk = ~clk;

    rsub_imm_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .src_val(src_val), .src_idx(src_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .carry_next(carry_next), .carry_flag(carry_flag)
    );

    typedef struct {
        logic        we;
        logic [4:0]  idx;
        logic [4:0]  sidx;
        logic        chk_data;
        logic [31:0] data;
        logic        cn;
        logic        cf;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    logic        m_carry = 1'b0;
    logic        m_armed = 1'b0;
    logic [15:0] m_hi = '0;
    logic        done = 1'b0;

    function automatic logic [31:0] mk(logic k, logic c, logic [4:0] rd,
                                       logic [4:0] ra, logic [15:0] imm);
        return {3'b001, k, c, 1'b1, rd, ra, imm};
    endfunction

    function automatic logic [31:0] mkpfx(logic [15:0] hi);
        return {6'b101100, 10'd0, hi};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: computes the expectation from the model, pushes it, updates the model.
    task automatic issue(logic v, logic [31:0] w, logic [31:0] s, string tag);
        exp_t e;
        logic match, pfx, k, c, cin;
        logic [31:0] imm;
        logic [32:0] sum;
        @(negedge clk);
        in_valid = v; in_word = w; src_val = s;
        match = v && (w[31:29] == 3'b001) && w[26];
        pfx   = (w[31:26] == 6'b101100) && (w[25:16] == 10'd0);
        k = w[28]; c = w[27];
        imm = m_armed ? {m_hi, w[15:0]} : {{16{w[15]}}, w[15:0]};
        cin = c ? m_carry : 1'b1;
        sum = {1'b0, ~s} + {1'b0, imm} + {32'd0, cin};
        e.we = match && (w[25:21] != 5'd0);
        e.idx = w[25:21];
        e.sidx = w[20:16];
        e.chk_data = match;
        e.data = sum[31:0];
        e.cn = (match && !k) ? sum[32] : m_carry;
        e.cf = m_carry;
        e.tag = tag;
        q.push_back(e);
        m_carry = e.cn;
        if (v) begin
            if (pfx) begin m_armed = 1'b1; m_hi = w[15:0]; end
            else m_armed = 1'b0;
        end
    endtask

    // Monitor: samples 1 ns after the driver's negedge.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "wr_en", {31'd0, wr_en}, {31'd0, e.we});
                if (e.we) check(e.tag, "wr_idx", {27'd0, wr_idx}, {27'd0, e.idx});
                check(e.tag, "src_idx", {27'd0, src_idx}, {27'd0, e.sidx});
                if (e.chk_data) check(e.tag, "wr_data", wr_data, e.data);
                check(e.tag, "carry_next", {31'd0, carry_next}, {31'd0, e.cn});
                check(e.tag, "carry_flag", {31'd0, carry_flag}, {31'd0, e.cf});
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check("R10", "carry_flag at reset", {31'd0, carry_flag}, 32'd0);
        check("R10", "wr_en at reset", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;
        // R2 R4: 10 - 3, no borrow
        issue(1, mk(0, 0, 5'd3, 5'd1, 16'd10), 32'd3, "R2");
        // R2 R4: 3 - 10, borrow
        issue(1, mk(0, 0, 5'd4, 5'd2, 16'd3), 32'd10, "R4");
        // R6 sign extension of 0xFFFF
        issue(1, mk(0, 0, 5'd5, 5'd1, 16'hFFFF), 32'd1, "R6");
        // R6 positive field, large source (borrow)
        issue(1, mk(0, 0, 5'd6, 5'd1, 16'h7FFF), 32'h8000_0000, "R6");
        // R3 use-carry with flag 0 from the borrow above
        issue(1, mk(0, 1, 5'd7, 5'd2, 16'd100), 32'd40, "R3");
        // R3 use-carry with flag 1
        issue(1, mk(0, 1, 5'd8, 5'd2, 16'd100), 32'd40, "R3");
        // R5 keep-carry: borrow but flag holds
        issue(1, mk(1, 0, 5'd9, 5'd3, 16'd1), 32'd50, "R5");
        // R5 keep-carry with use-carry
        issue(1, mk(1, 1, 5'd10, 5'd3, 16'd0), 32'd0, "R5");
        // R1 non-matching opcode
        issue(1, {6'b001000, 5'd11, 5'd1, 16'd0}, 32'hFFFF_FFFF, "R1");
        issue(1, {6'b011101, 5'd11, 5'd1, 16'd0}, 32'hFFFF_FFFF, "R1");
        // R1 strobe low
        issue(0, mk(0, 0, 5'd12, 5'd1, 16'd0), 32'd5, "R1");
        // R9 rd zero: no write, carry still updated (borrow)
        issue(1, mk(0, 0, 5'd0, 5'd1, 16'd0), 32'd5, "R9");
        // R7 prefix then consumer, with use-carry chained (flag 0 now)
        issue(1, mk(0, 0, 5'd1, 5'd1, 16'd9), 32'd2, "R4");
        issue(1, mkpfx(16'h1234), 32'd0, "R7");
        issue(1, mk(0, 1, 5'd13, 5'd1, 16'h8001), 32'h0000_0001, "R7");
        issue(1, mk(0, 0, 5'd14, 5'd1, 16'h8001), 32'd1, "R6");
        // R8 idle cycle does not drop the prefix
        issue(1, mkpfx(16'hABCD), 32'd0, "R7");
        issue(0, 32'd0, 32'd0, "R8");
        issue(1, mk(0, 0, 5'd15, 5'd1, 16'h0002), 32'd1, "R8");
        // R8 non-matching word drops the prefix
        issue(1, mkpfx(16'h00FF), 32'd0, "R7");
        issue(1, {6'b000000, 5'd2, 5'd1, 16'd0}, 32'd0, "R8");
        issue(1, mk(0, 0, 5'd16, 5'd1, 16'hF000), 32'd1, "R8");
        // R7 prefix followed by prefix: the second value wins
        issue(1, mkpfx(16'h1111), 32'd0, "R7");
        issue(1, mkpfx(16'h2222), 32'd0, "R7");
        issue(1, mk(1, 0, 5'd17, 5'd1, 16'h0000), 32'd0, "R7");
        // R10 reset disarms the prefix and clears the carry
        issue(1, mk(0, 0, 5'd18, 5'd1, 16'd5), 32'd1, "R4");
        issue(1, mkpfx(16'h5555), 32'd0, "R7");
        @(negedge clk); #2;
        while (q.size() > 0) @(negedge clk);
        rst_n = 1'b0;
        m_carry = 1'b0; m_armed = 1'b0;
        in_valid = 1'b0;
        @(negedge clk); #1;
        check("R10", "carry_flag after reset", {31'd0, carry_flag}, 32'd0);
        rst_n = 1'b1;
        issue(1, mk(0, 0, 5'd19, 5'd1, 16'hFFF0), 32'd0, "R10");
        issue(0, 32'd0, 32'd0, "R10");
        repeat (3) @(negedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule